// File: doc/BRIEF.md
# Linked Buffer Descriptor Walker

This block drives a serial flash or peripheral shifter from a chain of buffer descriptors kept in system memory. Software lays out the descriptors, points the block at the first one, sets the enable input and pulses start. The block then fetches each descriptor through a single-word read port, turns it into one transfer command for the downstream shifter, waits until the shifter reports that the transfer is over, and moves on along the chain's next pointer. The walk ends at a descriptor flagged as the end of the list.

A descriptor occupies four consecutive 32-bit words: control, status, buffer address and next-descriptor address. The status word is never read. The control word supplies the byte count, the direction, the lane width, a double-data-rate flag, the bit order, a chip-select index, a flag that releases chip select after the transfer, and a last-data-of-packet flag. All of these travel to the shifter with the buffer address. The control word also carries two interrupt request flags, one for each completed descriptor and one for the completed packet. A hardware-ownership bit guards each descriptor. When that bit is clear, the block either reports an error or, if polling is on, reads the control word again until software hands the descriptor over.

Three single-cycle event outputs are provided: descriptor done, packet complete and descriptor error. An interrupt controller next to the block can gate these.

Top module: `bd_chain_engine`

## Requirements
- R1: After reset, `active`, `memReq`, `cmdValid` and all three event outputs are 0. A start pulse seen while idle with `ctrlEn` high loads `baseAddr` as the current descriptor and begins fetching. A start pulse while `ctrlEn` is low is ignored, and the block stays idle with `memReq` low.
- R2: For each descriptor the block reads byte offsets 0 (control), 8 (buffer address) and 12 (next pointer), in that order, and never offset 4. `memReq` and `memAddr` are held until a cycle with `memAck` high, and `memData` is taken in that cycle.
- R3: Each issued command carries these values: `cmdLen` from control bits 8:0, `cmdLastData` from bit 18, `cmdRecv` from bit 20, `cmdDdr` from bit 21, `cmdDual` from bit 22, `cmdQuad` from bit 23, `cmdLsbFirst` from bit 25, `cmdCs` from bits 29:28 and `cmdRelease` from bit 30. `cmdBufAddr` comes from the buffer-address word. All of these stay stable while `cmdValid` waits for `cmdReady`.
- R4: Exactly one command is issued per owned descriptor with a nonzero length. `cmdValid` stays high until `cmdReady`. The next descriptor is not fetched before `xferDone` has been seen for the current transfer.
- R5: After a descriptor completes, the block follows its next pointer. It stops and returns to idle after completing a descriptor whose control bit 19 (end of list) is set.
- R6: `evtDescDone` pulses for one cycle when a descriptor with control bit 16 set completes.
- R7: `evtPktDone` pulses for one cycle when a descriptor with both bit 19 and bit 17 set completes.
- R8: When a fetched control word has bit 31 (hardware owned) clear and `ctrlPoll` is low, `evtDmaErr` pulses for one cycle. No command is issued for that descriptor, and the block returns to idle.
- R9: A length field greater than `MAX_LEN` (256) is treated as a bad descriptor: `evtDmaErr` pulses, no command is issued, and the block goes idle.
- R10: When bit 31 is clear and `ctrlPoll` is high, no error is raised. The control word is read again every `POLL_GAP` cycles until the bit is set. Clearing `ctrlEn` while polling returns the block to idle without an error.
- R11: A descriptor of length 0 issues no command but still completes. It raises its descriptor-done and packet-complete events and follows its chaining.
- R12: Clearing `ctrlEn` during a walk lets the descriptor in progress finish. The block then goes idle without fetching the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlEn | input | 1 | Engine enable; clearing it aborts at the next descriptor boundary |
| ctrlPoll | input | 1 | Re-read descriptors not yet owned by hardware instead of failing |
| ctrlStart | input | 1 | Start pulse |
| baseAddr | input | ADDR_W | Byte address of the first descriptor |
| memReq | output | 1 | Word read request |
| memAddr | output | ADDR_W | Byte address of the requested word |
| memAck | input | 1 | Read data valid; completes the request |
| memData | input | 32 | Read data |
| cmdValid | output | 1 | Transfer command valid |
| cmdReady | input | 1 | Shifter accepts the command |
| cmdBufAddr | output | ADDR_W | Data buffer address |
| cmdLen | output | 9 | Byte count |
| cmdRecv | output | 1 | 1 = receive, 0 = transmit |
| cmdDdr | output | 1 | Double data rate |
| cmdDual | output | 1 | Two data lanes |
| cmdQuad | output | 1 | Four data lanes |
| cmdLsbFirst | output | 1 | Least significant bit first |
| cmdCs | output | 2 | Chip-select index |
| cmdRelease | output | 1 | Release chip select after this transfer |
| cmdLastData | output | 1 | Last data of the packet |
| xferDone | input | 1 | Shifter finished the accepted command (one-cycle pulse) |
| evtDescDone | output | 1 | Descriptor-done event pulse |
| evtPktDone | output | 1 | Packet-complete event pulse |
| evtDmaErr | output | 1 | Bad-descriptor event pulse |
| active | output | 1 | Walk in progress |

## Verification
Each result has a fixed point in time:

- **Memory words:** a word is consumed on the rising edge where `memReq` and `memAck` are both high.
- **Command handshake:** a command is taken on the edge where `cmdValid` meets `cmdReady`. The bench records it from the values it sees at the falling edge just before that edge.
- **Error pulse:** `evtDmaErr` appears two cycles after the control word is captured, one cycle to decode and one in the error state.
- **Completion pulses:** descriptor-done and packet-complete appear in the cycle after `xferDone`, or in the cycle after the next pointer is captured for a zero-length descriptor.

All outputs are sampled at falling edges. Event pulses are counted once per falling edge, so each one-cycle pulse counts exactly once. Instead of fixed delays, the bench waits for `active` to fall and then compares the recorded commands and event counts with a chain walk computed from its own memory image.

// File: rtl/bdce_pkg.sv
package bdce_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 9;
  localparam int CS_W   = 2;

  // control word bit positions (fixed by the descriptor format)
  localparam int LenMsb      = 8;
  localparam int DescIrqBit  = 16;
  localparam int PktIrqBit   = 17;
  localparam int LastDataBit = 18;
  localparam int EndListBit  = 19;
  localparam int RecvBit     = 20;
  localparam int DdrBit      = 21;
  localparam int DualBit     = 22;
  localparam int QuadBit     = 23;
  localparam int LsbBit      = 25;
  localparam int CsLsb       = 28;
  localparam int ReleaseBit  = 30;
  localparam int OwnBit      = 31;

  // word index inside a descriptor
  typedef enum logic [1:0] {
    WordCtrl = 2'd0,
    WordStat = 2'd1,
    WordBuf  = 2'd2,
    WordNext = 2'd3
  } wordSelT;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadBase;
    logic    advance;
    logic    capCtrl;
    logic    capBuf;
    logic    capNext;
    wordSelT wordSel;
  } dpStrobeT;

  // decoded descriptor state from datapath to control
  typedef struct packed {
    logic owned;
    logic lenZero;
    logic lenTooBig;
    logic endOfList;
    logic wantDescIrq;
    logic wantPktIrq;
  } dpStatusT;

  typedef enum logic [3:0] {
    StIdle,
    StRdCtrl,
    StCheck,
    StPoll,
    StRdBuf,
    StRdNext,
    StIssue,
    StWaitDone,
    StComplete,
    StError
  } walkStateT;

endpackage

// File: rtl/bdce_datapath.sv
module bdce_datapath
  import bdce_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_LEN = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobeT            strobe,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [WORD_W-1:0]   memData,
  output logic [ADDR_W-1:0]   memAddr,
  output dpStatusT            status,
  output logic [ADDR_W-1:0]   cmdBufAddr,
  output logic [LEN_W-1:0]    cmdLen,
  output logic                cmdRecv,
  output logic                cmdDdr,
  output logic                cmdDual,
  output logic                cmdQuad,
  output logic                cmdLsbFirst,
  output logic [CS_W-1:0]     cmdCs,
  output logic                cmdRelease,
  output logic                cmdLastData
);

  localparam int PadW = ADDR_W - 4;

  logic [ADDR_W-1:0] curAddr;
  logic [WORD_W-1:0] ctrlWord;
  logic [ADDR_W-1:0] bufWord;
  logic [ADDR_W-1:0] nextWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      ctrlWord <= '0;
      bufWord  <= '0;
      nextWord <= '0;
    end else begin
      if (strobe.loadBase)     curAddr  <= baseAddr;
      else if (strobe.advance) curAddr  <= nextWord;
      if (strobe.capCtrl)      ctrlWord <= memData;
      if (strobe.capBuf)       bufWord  <= memData[ADDR_W-1:0];
      if (strobe.capNext)      nextWord <= memData[ADDR_W-1:0];
    end
  end

  assign memAddr = curAddr + {{PadW{1'b0}}, strobe.wordSel, 2'b00};

  logic [LEN_W-1:0] lenField;
  assign lenField = ctrlWord[LenMsb:0];

  always_comb begin
    status.owned       = ctrlWord[OwnBit];
    status.lenZero     = (lenField == '0);
    status.lenTooBig   = (32'(lenField) > 32'(MAX_LEN));
    status.endOfList   = ctrlWord[EndListBit];
    status.wantDescIrq = ctrlWord[DescIrqBit];
    status.wantPktIrq  = ctrlWord[PktIrqBit];
  end

  assign cmdBufAddr  = bufWord;
  assign cmdLen      = lenField;
  assign cmdRecv     = ctrlWord[RecvBit];
  assign cmdDdr      = ctrlWord[DdrBit];
  assign cmdDual     = ctrlWord[DualBit];
  assign cmdQuad     = ctrlWord[QuadBit];
  assign cmdLsbFirst = ctrlWord[LsbBit];
  assign cmdCs       = ctrlWord[CsLsb+CS_W-1:CsLsb];
  assign cmdRelease  = ctrlWord[ReleaseBit];
  assign cmdLastData = ctrlWord[LastDataBit];

  // R2: a capture never targets the status word
  p_no_status_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capCtrl || strobe.capBuf || strobe.capNext) |-> strobe.wordSel != WordStat);

  // R2: at most one register update strobe per cycle
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadBase, strobe.advance, strobe.capCtrl, strobe.capBuf, strobe.capNext}));

  // R5: the address only moves between descriptors while no word is captured
  p_addr_moves_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capCtrl || strobe.capBuf) |=> $stable(curAddr));

endmodule

// File: rtl/bdce_ctrl.sv
module bdce_ctrl
  import bdce_pkg::*;
#(
  parameter int POLL_GAP = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ctrlEn,
  input  logic     ctrlPoll,
  input  logic     ctrlStart,
  input  logic     memAck,
  input  logic     cmdReady,
  input  logic     xferDone,
  input  dpStatusT status,
  output dpStrobeT strobe,
  output logic     memReq,
  output logic     cmdValid,
  output logic     evtDescDone,
  output logic     evtPktDone,
  output logic     evtDmaErr,
  output logic     active
);

  localparam int PollW = $clog2(POLL_GAP + 1);
  localparam logic [PollW-1:0] PollLast = PollW'(POLL_GAP - 1);

  walkStateT state, nextState;
  logic [PollW-1:0] pollCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= StIdle;
      pollCnt <= '0;
    end else begin
      state   <= nextState;
      pollCnt <= (state == StPoll) ? pollCnt + 1'b1 : '0;
    end
  end

  always_comb begin
    nextState      = state;
    strobe         = '0;
    strobe.wordSel = WordCtrl;
    memReq         = 1'b0;
    cmdValid       = 1'b0;
    evtDescDone    = 1'b0;
    evtPktDone     = 1'b0;
    evtDmaErr      = 1'b0;
    unique case (state)
      StIdle: begin
        if (ctrlStart && ctrlEn) begin
          strobe.loadBase = 1'b1;
          nextState       = StRdCtrl;
        end
      end
      StRdCtrl: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.capCtrl = 1'b1;
          nextState      = StCheck;
        end
      end
      StCheck: begin
        if (!status.owned) begin
          if (ctrlPoll) nextState = ctrlEn ? StPoll : StIdle;
          else          nextState = StError;
        end else if (status.lenTooBig) begin
          nextState = StError;
        end else begin
          nextState = StRdBuf;
        end
      end
      StPoll: begin
        if (!ctrlEn)                nextState = StIdle;
        else if (pollCnt == PollLast) nextState = StRdCtrl;
      end
      StRdBuf: begin
        memReq         = 1'b1;
        strobe.wordSel = WordBuf;
        if (memAck) begin
          strobe.capBuf = 1'b1;
          nextState     = StRdNext;
        end
      end
      StRdNext: begin
        memReq         = 1'b1;
        strobe.wordSel = WordNext;
        if (memAck) begin
          strobe.capNext = 1'b1;
          nextState      = status.lenZero ? StComplete : StIssue;
        end
      end
      StIssue: begin
        cmdValid = 1'b1;
        if (cmdReady) nextState = StWaitDone;
      end
      StWaitDone: begin
        if (xferDone) nextState = StComplete;
      end
      StComplete: begin
        evtDescDone = status.wantDescIrq;
        if (status.endOfList) begin
          evtPktDone = status.wantPktIrq;
          nextState  = StIdle;
        end else if (!ctrlEn) begin
          nextState = StIdle;
        end else begin
          strobe.advance = 1'b1;
          nextState      = StRdCtrl;
        end
      end
      StError: begin
        evtDmaErr = 1'b1;
        nextState = StIdle;
      end
      default: nextState = StIdle;
    endcase
  end

  assign active = (state != StIdle);

  // R1: an enabled start from idle begins the walk
  p_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!active && ctrlStart && ctrlEn) |=> active);

  // R1: start without enable leaves the block idle
  p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !ctrlEn) |=> !active);

  // R2: a read request is held until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  // R4: a command is held until accepted
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> cmdValid);

  // R4: no read is issued while a command is pending
  p_no_read_in_cmd_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !memReq);

  // R8: commands only come from owned descriptors of legal length
  p_cmd_owned_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (status.owned && !status.lenTooBig && !status.lenZero));

  // R8: an error pulse ends the walk and stands alone
  p_err_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    evtDmaErr |=> (!active && !evtDmaErr));

  // R5: a packet-complete pulse ends the walk
  p_pkt_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
    evtPktDone |=> !active);

  // R7: packet-complete only together with a completing end-of-list descriptor
  p_pkt_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    evtPktDone |-> (status.endOfList && !evtDmaErr));

endmodule

// File: rtl/bd_chain_engine.sv
module bd_chain_engine
  import bdce_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_LEN  = 256,
  parameter int POLL_GAP = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlEn,
  input  logic              ctrlPoll,
  input  logic              ctrlStart,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [31:0]       memData,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [ADDR_W-1:0] cmdBufAddr,
  output logic [8:0]        cmdLen,
  output logic              cmdRecv,
  output logic              cmdDdr,
  output logic              cmdDual,
  output logic              cmdQuad,
  output logic              cmdLsbFirst,
  output logic [1:0]        cmdCs,
  output logic              cmdRelease,
  output logic              cmdLastData,
  input  logic              xferDone,
  output logic              evtDescDone,
  output logic              evtPktDone,
  output logic              evtDmaErr,
  output logic              active
);

  dpStrobeT strobe;
  dpStatusT status;

  bdce_ctrl #(.POLL_GAP(POLL_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlEn(ctrlEn), .ctrlPoll(ctrlPoll), .ctrlStart(ctrlStart),
    .memAck(memAck), .cmdReady(cmdReady), .xferDone(xferDone),
    .status(status), .strobe(strobe),
    .memReq(memReq), .cmdValid(cmdValid),
    .evtDescDone(evtDescDone), .evtPktDone(evtPktDone), .evtDmaErr(evtDmaErr),
    .active(active)
  );

  bdce_datapath #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .baseAddr(baseAddr), .memData(memData),
    .memAddr(memAddr), .status(status),
    .cmdBufAddr(cmdBufAddr), .cmdLen(cmdLen), .cmdRecv(cmdRecv),
    .cmdDdr(cmdDdr), .cmdDual(cmdDual), .cmdQuad(cmdQuad),
    .cmdLsbFirst(cmdLsbFirst), .cmdCs(cmdCs), .cmdRelease(cmdRelease),
    .cmdLastData(cmdLastData)
  );

  // R3: command fields hold while the shifter stalls
  p_cmd_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> $stable({cmdBufAddr, cmdLen, cmdRecv, cmdDdr, cmdDual,
                                         cmdQuad, cmdLsbFirst, cmdCs, cmdRelease, cmdLastData}));

  // R2: request address holds until the word arrives
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr));

endmodule

// File: tb/test_bd_chain_engine.sv
`timescale 1ns/1ps
module test_bd_chain_engine;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ctrlEn, ctrlPoll, ctrlStart;
  logic [31:0] baseAddr;
  logic        memReq, memAck;
  logic [31:0] memAddr, memData;
  logic        cmdValid, cmdReady;
  logic [31:0] cmdBufAddr;
  logic [8:0]  cmdLen;
  logic        cmdRecv, cmdDdr, cmdDual, cmdQuad, cmdLsbFirst, cmdRelease, cmdLastData;
  logic [1:0]  cmdCs;
  logic        xferDone;
  logic        evtDescDone, evtPktDone, evtDmaErr, active;

  always #10 clk = ~clk;

  bd_chain_engine i_bd_chain_engine (
    .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .ctrlPoll(ctrlPoll), .ctrlStart(ctrlStart),
    .baseAddr(baseAddr), .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
    .memData(memData), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdBufAddr(cmdBufAddr), .cmdLen(cmdLen), .cmdRecv(cmdRecv), .cmdDdr(cmdDdr),
    .cmdDual(cmdDual), .cmdQuad(cmdQuad), .cmdLsbFirst(cmdLsbFirst), .cmdCs(cmdCs),
    .cmdRelease(cmdRelease), .cmdLastData(cmdLastData), .xferDone(xferDone),
    .evtDescDone(evtDescDone), .evtPktDone(evtPktDone), .evtDmaErr(evtDmaErr),
    .active(active)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] memArr [0:255];
  logic [63:0] recCmds [0:31];
  int recN, descCnt, pktCnt, errCnt, badRd;
  logic [63:0] expCmds [0:31];
  int expN, expDesc, expPkt, expErr;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one-cycle ack after a random wait
  initial begin
    int memWait;
    memAck = 0; memData = '0; memWait = 0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 0;
      else if (memReq) begin
        if (memWait > 0) memWait--;
        else begin
          memAck  = 1;
          memData = memArr[memAddr[9:2]];
          memWait = $urandom % 3;
          if (!(memAddr[3:0] == 4'h0 || memAddr[3:0] == 4'h8 || memAddr[3:0] == 4'hC)) badRd++;
        end
      end
    end
  end

  // shifter model: records the command taken at the coming edge, then pulses done
  initial begin
    bit offered;
    logic [63:0] saved;
    int shiftCnt;
    cmdReady = 0; xferDone = 0; offered = 0; shiftCnt = 0; saved = '0;
    forever begin
      @(negedge clk);
      xferDone = 0;
      if (offered) begin
        if (recN < 32) recCmds[recN] = saved;
        recN++;
        cmdReady = 0;
        shiftCnt = 1 + $urandom % 4;
      end else if (shiftCnt > 0) begin
        shiftCnt--;
        if (shiftCnt == 0) xferDone = 1;
      end else begin
        cmdReady = ($urandom % 3 != 0);
      end
      offered = cmdValid && cmdReady;
      saved = {14'b0, cmdBufAddr, cmdLen, cmdRecv, cmdDdr, cmdDual, cmdQuad,
               cmdLsbFirst, cmdCs, cmdRelease, cmdLastData};
    end
  end

  // event monitor
  initial begin
    forever begin
      @(negedge clk);
      if (evtDescDone) descCnt++;
      if (evtPktDone)  pktCnt++;
      if (evtDmaErr)   errCnt++;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic clearLogs();
    recN = 0; descCnt = 0; pktCnt = 0; errCnt = 0; badRd = 0;
  endtask

  task automatic pulseStart(input int baseSlot);
    @(negedge clk);
    baseAddr  = baseSlot * 16;
    ctrlStart = 1;
    @(negedge clk);
    ctrlStart = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (active && n < 4000) begin @(negedge clk); n++; end
    if (active) chk(0, "watchdog idle", 1, 0);
    repeat (3) @(negedge clk);
  endtask

  // expected walk over the bench memory image
  task automatic computeExp(input int baseSlot);
    int slot = baseSlot;
    expN = 0; expDesc = 0; expPkt = 0; expErr = 0;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] c;
      c = memArr[slot*4];
      if (!c[31] || c[8:0] > 9'd256) begin expErr = 1; break; end
      if (c[8:0] != 0) begin
        expCmds[expN] = {14'b0, memArr[slot*4+2], c[8:0], c[20], c[21], c[22], c[23],
                         c[25], c[29:28], c[30], c[18]};
        expN++;
      end
      if (c[16]) expDesc++;
      if (c[19]) begin if (c[17]) expPkt++; break; end
      slot = int'(memArr[slot*4+3][9:4]);
    end
  endtask

  // badKind: 0 none, 1 not owned, 2 oversize, 3 forced zero length
  task automatic buildChain(input int n, input int badPos, input int badKind, output int baseSlot);
    int start = $urandom % 64;
    for (int i = 0; i < n; i++) begin
      int slot = (start + 5*i) % 64;
      int nxt  = (start + 5*(i+1)) % 64;
      logic [31:0] c;
      c = $urandom;
      c[31] = 1;
      c[19] = (i == n-1);
      c[8:0] = ($urandom % 5 == 0) ? 9'd0 : 9'(1 + $urandom % 256);
      if (i == badPos) begin
        if (badKind == 1) c[31] = 0;
        if (badKind == 2) c[8:0] = 9'(257 + $urandom % 255);
        if (badKind == 3) c[8:0] = 9'd0;
      end
      memArr[slot*4]   = c;
      memArr[slot*4+1] = $urandom;
      memArr[slot*4+2] = $urandom;
      memArr[slot*4+3] = nxt * 16;
    end
    baseSlot = start;
  endtask

  task automatic compareRun(input int baseSlot);
    computeExp(baseSlot);
    chk(recN == expN, "R4 R5 command count", recN, expN);
    for (int i = 0; i < expN && i < recN; i++)
      chk(recCmds[i] == expCmds[i], "R3 command fields", recCmds[i], expCmds[i]);
    chk(descCnt == expDesc, "R6 descriptor done events", descCnt, expDesc);
    chk(pktCnt == expPkt, "R7 packet complete events", pktCnt, expPkt);
    chk(errCnt == expErr, "R8 R9 error events", errCnt, expErr);
    chk(badRd == 0, "R2 word offsets", badRd, 0);
  endtask

  initial begin
    int base;
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) memArr[i] = '0;
    rstN = 0; ctrlEn = 0; ctrlPoll = 0; ctrlStart = 0; baseAddr = '0;
    clearLogs();
    repeat (3) @(negedge clk);
    chk(!active && !memReq && !cmdValid, "R1 reset idle", {active, memReq, cmdValid}, 0);
    chk(!evtDescDone && !evtPktDone && !evtDmaErr, "R1 reset events",
        {evtDescDone, evtPktDone, evtDmaErr}, 0);
    rstN = 1;
    @(negedge clk);

    // R1: start with enable clear is ignored
    buildChain(2, -1, 0, base);
    pulseStart(base);
    repeat (5) @(negedge clk);
    chk(!active && !memReq, "R1 start ignored when disabled", {active, memReq}, 0);
    chk(recN == 0, "R1 no command when disabled", recN, 0);

    // directed: zero-length middle descriptor with all flags set (R11)
    clearLogs();
    buildChain(3, 1, 3, base);
    memArr[((base + 5) % 64)*4][16] = 1;
    memArr[((base + 10) % 64)*4][17] = 1;
    ctrlEn = 1;
    pulseStart(base);
    waitIdle();
    compareRun(base);
    chk(descCnt >= 1, "R11 zero length still completes", descCnt, 1);

    // directed: unowned first descriptor, polling off (R8)
    clearLogs();
    buildChain(2, 0, 1, base);
    pulseStart(base);
    waitIdle();
    chk(errCnt == 1 && recN == 0, "R8 unowned error", {errCnt[7:0], recN[7:0]}, 16'h0100);

    // directed: oversize length at second descriptor (R9)
    clearLogs();
    buildChain(3, 1, 2, base);
    pulseStart(base);
    waitIdle();
    compareRun(base);
    chk(errCnt == 1, "R9 oversize error", errCnt, 1);

    // directed: polling until ownership arrives (R10)
    clearLogs();
    ctrlPoll = 1;
    buildChain(1, 0, 1, base);
    memArr[base*4][8:0] = 9'd5;
    pulseStart(base);
    repeat (60) @(negedge clk);
    chk(active && recN == 0 && errCnt == 0, "R10 polling waits",
        {active, recN[7:0], errCnt[7:0]}, 17'h10000);
    memArr[base*4][31] = 1;
    waitIdle();
    chk(recN == 1 && errCnt == 0, "R10 proceeds once owned", {recN[7:0], errCnt[7:0]}, 16'h0100);

    // directed: enable cleared while polling (R10)
    clearLogs();
    buildChain(1, 0, 1, base);
    pulseStart(base);
    repeat (20) @(negedge clk);
    ctrlEn = 0;
    waitIdle();
    chk(!active && errCnt == 0, "R10 poll abort no error", {active, errCnt[7:0]}, 0);
    ctrlPoll = 0;

    // directed: abort after first command (R12)
    clearLogs();
    buildChain(4, -1, 0, base);
    for (int i = 0; i < 4; i++) memArr[((base + 5*i) % 64)*4][8:0] = 9'd16;
    ctrlEn = 1;
    pulseStart(base);
    begin
      int n = 0;
      while (recN == 0 && n < 2000) begin @(negedge clk); n++; end
    end
    ctrlEn = 0;
    waitIdle();
    chk(recN == 1, "R12 abort after current descriptor", recN, 1);
    chk(pktCnt == 0 && !active, "R12 no packet complete on abort", {pktCnt[7:0], active}, 0);

    // random chains (R3 R4 R5 R6 R7 R8 R9 R11)
    ctrlEn = 1;
    for (int r = 0; r < 24; r++) begin
      int n = 1 + $urandom % 6;
      int kind = ($urandom % 4 == 0) ? 1 + $urandom % 2 : 0;
      clearLogs();
      buildChain(n, $urandom % n, kind, base);
      pulseStart(base);
      waitIdle();
      compareRun(base);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule